// File: doc/BRIEF.md
# Branch Target Resolution Unit

This unit settles the control-flow outcome of one already-decoded branch per clock. For each valid descriptor it uses the branch address, one operand register value, one target register value and the four condition flags. From these it decides whether the branch is taken and computes the address of the next instruction. For call-type branches it also produces a write of the return address into the link register. It also supplies a combinational register-select output, so that the register file read for indirect branches can be steered. A plain return with no register named reads the link register.

Eight branch kinds share one datapath. Compare-against-zero and single-bit-test branches depend on the operand register. Flag-condition branches depend on the flags. PC-relative jumps and calls use an immediate offset whose field width depends on the kind. Register jumps, register calls and returns go to the target value. Every result is registered, so it appears one cycle after its descriptor.

Top module: `branch_resolve`

## Requirements
- R1: A descriptor presented with `in_valid` high produces its result on the outputs in the next cycle with `out_valid` high. A cycle with `in_valid` low produces `out_valid` low in the next cycle.
- R2: Kind 0 (compare-zero) with `in_invert`=0 is taken when the operand is zero. With `in_invert`=1 it is taken when the operand is non-zero. `in_wide`=0 looks only at operand bits [31:0]. `in_wide`=1 looks at all 64 bits.
- R3: Kind 1 (bit test) examines operand bit `in_bit` (0..63). With `in_invert`=0 it is taken when that bit is 0. With `in_invert`=1 it is taken when that bit is 1.
- R4: Kind 2 (flag condition) is taken when the 4-bit code in `in_cond` holds for `in_flags` = {N,Z,C,V} (bit 3 down to 0). Codes 0..13 are EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT, LE. Codes 14 and 15 always hold.
- R5: Immediate offsets are counted in words, sign-extended from their field and multiplied by 4 before being added to the branch address. Kind 1 uses `in_imm[13:0]`, kinds 0 and 2 use `in_imm[18:0]`, and kinds 3 and 4 use all 26 bits. Higher bits are ignored.
- R6: A valid branch that is not taken gives `out_next_pc` = branch address + 4.
- R7: Kinds 4 (call) and 6 (register call) raise `out_link_we` with `out_link_idx` = 30 and `out_link_data` = branch address + 4. No other kind raises `out_link_we`.
- R8: Kinds 5 (register jump), 6 and 7 (return) go to `in_tgt`. `tgt_sel` equals `in_reg_idx`, except for kind 7 with `in_reg_given`=0, where it is 30.
- R9: Kind 7 raises `out_hint_ret` and kind 5 raises `out_hint_jmp`. The two never rise together, and no other kind raises either.
- R10: During reset, and in a cycle after an idle input, `out_valid`, `out_taken`, `out_link_we` and both hints are low. Reset also clears `out_next_pc`.
- R11: Kinds 3 through 7 are always taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present this cycle |
| in_kind | input | 3 | Branch kind 0..7 |
| in_invert | input | 1 | Selects the non-zero / bit-set polarity |
| in_wide | input | 1 | 1: compare all 64 bits, 0: low 32 bits |
| in_bit | input | 6 | Bit number for bit-test branches |
| in_cond | input | 4 | Condition code |
| in_imm | input | 26 | Word offset field |
| in_reg_given | input | 1 | Return names an explicit register |
| in_reg_idx | input | 5 | Register index from the descriptor |
| in_pc | input | 64 | Address of the branch |
| in_opnd | input | 64 | Operand register value |
| in_tgt | input | 64 | Target register value |
| in_flags | input | 4 | Flags {N,Z,C,V} |
| tgt_sel | output | 5 | Register to read for the target (combinational) |
| out_valid | output | 1 | Result valid |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | 64 | Address of the next instruction |
| out_link_we | output | 1 | Link register write enable |
| out_link_idx | output | 5 | Link register index |
| out_link_data | output | 64 | Return address to write |
| out_hint_ret | output | 1 | Subroutine-return hint |
| out_hint_jmp | output | 1 | Not-a-return hint for register jumps |

## Verification
`tgt_sel` is combinational and is sampled in the same half-cycle in which its inputs are driven. All other results pass through exactly one register stage. The bench drives each descriptor on a falling edge, lets one rising edge capture it, and samples on the following falling edge. It then drives the next descriptor, so the table runs back to back with no idle cycle. The idle and reset checks look at the first falling edge after the clearing rising edge.

// File: rtl/brr_pkg.sv
package brr_pkg;
   typedef enum logic [2:0] {
      BK_CMPZ    = 3'd0,
      BK_TBIT    = 3'd1,
      BK_COND    = 3'd2,
      BK_JMP     = 3'd3,
      BK_CALL    = 3'd4,
      BK_JREG    = 3'd5,
      BK_CALLREG = 3'd6,
      BK_RET     = 3'd7
   } br_kind_e;

   localparam int FL_N = 3;
   localparam int FL_Z = 2;
   localparam int FL_C = 1;
   localparam int FL_V = 0;
endpackage

// File: rtl/brr_cond_eval.sv
module brr_cond_eval
   import brr_pkg::*;
(
   input  logic [3:0] cond,
   input  logic [3:0] flags,
   output logic       pass
);
   logic base;
   logic n, z, c, v;

   assign n = flags[FL_N];
   assign z = flags[FL_Z];
   assign c = flags[FL_C];
   assign v = flags[FL_V];

   always_comb begin
      unique case (cond[3:1])
         3'b000:  base = z;
         3'b001:  base = c;
         3'b010:  base = n;
         3'b011:  base = v;
         3'b100:  base = c & ~z;
         3'b101:  base = (n == v);
         3'b110:  base = (n == v) & ~z;
         default: base = 1'b1;
      endcase
      pass = (cond[3:1] == 3'b111) ? 1'b1 : (base ^ cond[0]);
   end
endmodule

// File: rtl/brr_zero_test.sv
module brr_zero_test #(
   parameter int DATA_W = 64,
   parameter int HALF_W = 32,
   localparam int BIT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] opnd,
   input  logic              wide,
   input  logic              invert,
   input  logic [BIT_W-1:0]  bit_no,
   output logic              cz_taken,
   output logic              tb_taken
);
   logic is_zero;
   logic sel_bit;

   generate
      if (DATA_W > HALF_W) begin : g_dual_view
         logic lo_zero, hi_zero;
         assign lo_zero = (opnd[HALF_W-1:0] == '0);
         assign hi_zero = (opnd[DATA_W-1:HALF_W] == '0);
         assign is_zero = lo_zero & (hi_zero | ~wide);
      end else begin : g_single_view
         assign is_zero = (opnd == '0);
      end
   endgenerate

   assign sel_bit  = opnd[bit_no];
   assign cz_taken = is_zero ^ invert;
   assign tb_taken = (sel_bit == invert);
endmodule

// File: rtl/brr_target_gen.sv
module brr_target_gen
   import brr_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int IMM_W     = 26,
   parameter int TB_OFF_W  = 14,
   parameter int CMP_OFF_W = 19,
   parameter int JMP_OFF_W = 26
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [IMM_W-1:0]  imm,
   input  br_kind_e          kind,
   input  logic [ADDR_W-1:0] reg_tgt,
   output logic [ADDR_W-1:0] seq_pc,
   output logic [ADDR_W-1:0] taken_pc
);
   localparam int N_FORMS = 3;
   localparam int FORM_W [N_FORMS] = '{TB_OFF_W, CMP_OFF_W, JMP_OFF_W};

   logic [ADDR_W-1:0] off [N_FORMS];
   logic [ADDR_W-1:0] sel_off;

   genvar gi;
   generate
      for (gi = 0; gi < N_FORMS; gi++) begin : g_off
         localparam int W = FORM_W[gi];
         assign off[gi] = {{(ADDR_W-W-2){imm[W-1]}}, imm[W-1:0], 2'b00};
      end
   endgenerate

   always_comb begin
      unique case (kind)
         BK_TBIT:          sel_off = off[0];
         BK_CMPZ, BK_COND: sel_off = off[1];
         default:          sel_off = off[2];
      endcase
   end

   assign seq_pc   = pc + ADDR_W'(4);
   assign taken_pc = (kind inside {BK_JREG, BK_CALLREG, BK_RET}) ? reg_tgt
                                                                 : pc + sel_off;
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
   import brr_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int DATA_W    = 64,
   parameter int REG_W     = 5,
   parameter int LINK_REG  = 30,
   parameter int TB_OFF_W  = 14,
   parameter int CMP_OFF_W = 19,
   parameter int JMP_OFF_W = 26,
   localparam int BIT_W    = $clog2(DATA_W),
   localparam int IMM_W    = JMP_OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        in_kind,
   input  logic              in_invert,
   input  logic              in_wide,
   input  logic [BIT_W-1:0]  in_bit,
   input  logic [3:0]        in_cond,
   input  logic [IMM_W-1:0]  in_imm,
   input  logic              in_reg_given,
   input  logic [REG_W-1:0]  in_reg_idx,
   input  logic [ADDR_W-1:0] in_pc,
   input  logic [DATA_W-1:0] in_opnd,
   input  logic [ADDR_W-1:0] in_tgt,
   input  logic [3:0]        in_flags,
   output logic [REG_W-1:0]  tgt_sel,
   output logic              out_valid,
   output logic              out_taken,
   output logic [ADDR_W-1:0] out_next_pc,
   output logic              out_link_we,
   output logic [REG_W-1:0]  out_link_idx,
   output logic [ADDR_W-1:0] out_link_data,
   output logic              out_hint_ret,
   output logic              out_hint_jmp
);
   generate
      if (ADDR_W < JMP_OFF_W + 3) begin : g_bad_addr
         $error("ADDR_W too narrow for the widest offset");
      end
      if (TB_OFF_W > CMP_OFF_W || CMP_OFF_W > JMP_OFF_W) begin : g_bad_off
         $error("offset widths must not decrease from bit-test to jump");
      end
      if (LINK_REG >= (1 << REG_W)) begin : g_bad_link
         $error("LINK_REG does not fit in REG_W bits");
      end
      if ((1 << BIT_W) != DATA_W) begin : g_bad_data
         $error("DATA_W must be a power of two");
      end
   endgenerate

   br_kind_e          kind;
   logic              cz_taken, tb_taken, cond_pass;
   logic              taken_d, link_d;
   logic [ADDR_W-1:0] seq_pc, taken_pc;

   assign kind = br_kind_e'(in_kind);

   brr_zero_test #(.DATA_W(DATA_W)) u_zt (
      .opnd     (in_opnd),
      .wide     (in_wide),
      .invert   (in_invert),
      .bit_no   (in_bit),
      .cz_taken (cz_taken),
      .tb_taken (tb_taken)
   );

   brr_cond_eval u_ce (
      .cond  (in_cond),
      .flags (in_flags),
      .pass  (cond_pass)
   );

   brr_target_gen #(
      .ADDR_W    (ADDR_W),
      .IMM_W     (IMM_W),
      .TB_OFF_W  (TB_OFF_W),
      .CMP_OFF_W (CMP_OFF_W),
      .JMP_OFF_W (JMP_OFF_W)
   ) u_tg (
      .pc       (in_pc),
      .imm      (in_imm),
      .kind     (kind),
      .reg_tgt  (in_tgt),
      .seq_pc   (seq_pc),
      .taken_pc (taken_pc)
   );

   always_comb begin
      unique case (kind)
         BK_CMPZ: taken_d = cz_taken;
         BK_TBIT: taken_d = tb_taken;
         BK_COND: taken_d = cond_pass;
         default: taken_d = 1'b1;
      endcase
   end

   assign link_d  = (kind == BK_CALL) || (kind == BK_CALLREG);
   assign tgt_sel = (kind == BK_RET && !in_reg_given) ? REG_W'(LINK_REG) : in_reg_idx;
   assign out_link_idx = REG_W'(LINK_REG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_taken     <= 1'b0;
         out_next_pc   <= '0;
         out_link_we   <= 1'b0;
         out_link_data <= '0;
         out_hint_ret  <= 1'b0;
         out_hint_jmp  <= 1'b0;
      end else begin
         out_valid    <= in_valid;
         out_taken    <= in_valid & taken_d;
         out_link_we  <= in_valid & link_d;
         out_hint_ret <= in_valid & (kind == BK_RET);
         out_hint_jmp <= in_valid & (kind == BK_JREG);
         if (in_valid) begin
            out_next_pc   <= taken_d ? taken_pc : seq_pc;
            out_link_data <= seq_pc;
         end
      end
   end
endmodule

// File: rtl/brr_checker.sv
module brr_checker #(
   parameter int ADDR_W   = 64,
   parameter int REG_W    = 5,
   parameter int LINK_REG = 30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2:0]        in_kind,
   input logic [ADDR_W-1:0] in_pc,
   input logic [ADDR_W-1:0] in_tgt,
   input logic              out_valid,
   input logic              out_taken,
   input logic [ADDR_W-1:0] out_next_pc,
   input logic              out_link_we,
   input logic [REG_W-1:0]  out_link_idx,
   input logic [ADDR_W-1:0] out_link_data,
   input logic              out_hint_ret,
   input logic              out_hint_jmp
);
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_seq_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid ##1 (out_valid && !out_taken) |-> out_next_pc == $past(in_pc) + ADDR_W'(4));
   p_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid ##1 out_link_we |-> out_taken && out_link_idx == REG_W'(LINK_REG)
                                   && out_link_data == $past(in_pc) + ADDR_W'(4));
   p_reg_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_kind >= 3'd5) |=> out_next_pc == $past(in_tgt));
   p_hint_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_hint_ret, out_hint_jmp}));
   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !out_taken && !out_link_we && !out_hint_ret && !out_hint_jmp);
   p_uncond_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_kind >= 3'd3) |=> out_taken);
endmodule

bind branch_resolve brr_checker #(
   .ADDR_W   (ADDR_W),
   .REG_W    (REG_W),
   .LINK_REG (LINK_REG)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .in_kind       (in_kind),
   .in_pc         (in_pc),
   .in_tgt        (in_tgt),
   .out_valid     (out_valid),
   .out_taken     (out_taken),
   .out_next_pc   (out_next_pc),
   .out_link_we   (out_link_we),
   .out_link_idx  (out_link_idx),
   .out_link_data (out_link_data),
   .out_hint_ret  (out_hint_ret),
   .out_hint_jmp  (out_hint_jmp)
);

// File: tb/branch_resolve_tb_top.sv
module branch_resolve_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [2:0]  in_kind;
   logic        in_invert, in_wide;
   logic [5:0]  in_bit;
   logic [3:0]  in_cond;
   logic [25:0] in_imm;
   logic        in_reg_given;
   logic [4:0]  in_reg_idx;
   logic [63:0] in_pc, in_opnd, in_tgt;
   logic [3:0]  in_flags;
   logic [4:0]  tgt_sel;
   logic        out_valid, out_taken, out_link_we, out_hint_ret, out_hint_jmp;
   logic [63:0] out_next_pc, out_link_data;
   logic [4:0]  out_link_idx;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   branch_resolve dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
      .in_invert(in_invert), .in_wide(in_wide), .in_bit(in_bit), .in_cond(in_cond),
      .in_imm(in_imm), .in_reg_given(in_reg_given), .in_reg_idx(in_reg_idx),
      .in_pc(in_pc), .in_opnd(in_opnd), .in_tgt(in_tgt), .in_flags(in_flags),
      .tgt_sel(tgt_sel), .out_valid(out_valid), .out_taken(out_taken),
      .out_next_pc(out_next_pc), .out_link_we(out_link_we), .out_link_idx(out_link_idx),
      .out_link_data(out_link_data), .out_hint_ret(out_hint_ret), .out_hint_jmp(out_hint_jmp)
   );

   typedef struct packed {
      logic [2:0]  kind;
      logic        inv;
      logic        wide;
      logic [5:0]  bitn;
      logic [3:0]  cond;
      logic [25:0] imm;
      logic [3:0]  flags;
      logic [63:0] pc;
      logic [63:0] opnd;
      logic [63:0] tgt;
      logic [3:0]  req;
      logic        e_taken;
      logic [63:0] e_next;
      logic        e_link;
      logic        e_ret;
      logic        e_jmp;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      // R2: compare-zero, both views and both polarities
      '{3'd0,1'b0,1'b1,6'd0,4'd0,26'h4,4'h0,64'h1000,64'h0,64'h0,4'd2,1'b1,64'h1010,1'b0,1'b0,1'b0},
      '{3'd0,1'b0,1'b1,6'd0,4'd0,26'h4,4'h0,64'h1000,64'h1_0000_0000,64'h0,4'd2,1'b0,64'h1004,1'b0,1'b0,1'b0},
      '{3'd0,1'b0,1'b0,6'd0,4'd0,26'h4,4'h0,64'h1000,64'h1_0000_0000,64'h0,4'd2,1'b1,64'h1010,1'b0,1'b0,1'b0},
      '{3'd0,1'b1,1'b0,6'd0,4'd0,26'h4,4'h0,64'h1000,64'hFFFF_FFFF_0000_0000,64'h0,4'd2,1'b0,64'h1004,1'b0,1'b0,1'b0},
      // R5: 19-bit field of -1 words, upper imm bits ignored
      '{3'd0,1'b1,1'b1,6'd0,4'd0,26'h3FF_FFFF,4'h0,64'h1000,64'hFFFF_FFFF_0000_0000,64'h0,4'd5,1'b1,64'h0FFC,1'b0,1'b0,1'b0},
      // R3: bit test
      '{3'd1,1'b0,1'b0,6'd63,4'd0,26'h4,4'h0,64'h1000,64'h8000_0000_0000_0000,64'h0,4'd3,1'b0,64'h1004,1'b0,1'b0,1'b0},
      // R5: most negative 14-bit offset (-32 KiB)
      '{3'd1,1'b1,1'b0,6'd63,4'd0,26'h2000,4'h0,64'h10000,64'h8000_0000_0000_0000,64'h0,4'd5,1'b1,64'h8000,1'b0,1'b0,1'b0},
      // R5: most positive 14-bit offset
      '{3'd1,1'b1,1'b0,6'd5,4'd0,26'h1FFF,4'h0,64'h1000,64'h20,64'h0,4'd5,1'b1,64'h8FFC,1'b0,1'b0,1'b0},
      '{3'd1,1'b0,1'b0,6'd5,4'd0,26'h4,4'h0,64'h1000,64'h20,64'h0,4'd3,1'b0,64'h1004,1'b0,1'b0,1'b0},
      // R4: condition codes, flags {N,Z,C,V}
      '{3'd2,1'b0,1'b0,6'd0,4'd0,26'h2,4'b0100,64'h1000,64'h0,64'h0,4'd4,1'b1,64'h1008,1'b0,1'b0,1'b0},
      '{3'd2,1'b0,1'b0,6'd0,4'd12,26'h3,4'b1000,64'h1000,64'h0,64'h0,4'd4,1'b0,64'h1004,1'b0,1'b0,1'b0},
      '{3'd2,1'b0,1'b0,6'd0,4'd11,26'h3,4'b0001,64'h1000,64'h0,64'h0,4'd4,1'b1,64'h100C,1'b0,1'b0,1'b0},
      '{3'd2,1'b0,1'b0,6'd0,4'd8,26'h3,4'b0010,64'h1000,64'h0,64'h0,4'd4,1'b1,64'h100C,1'b0,1'b0,1'b0},
      '{3'd2,1'b0,1'b0,6'd0,4'd9,26'h3,4'b0010,64'h1000,64'h0,64'h0,4'd4,1'b0,64'h1004,1'b0,1'b0,1'b0},
      '{3'd2,1'b0,1'b0,6'd0,4'd15,26'h3,4'b0000,64'h1000,64'h0,64'h0,4'd4,1'b1,64'h100C,1'b0,1'b0,1'b0},
      '{3'd2,1'b0,1'b0,6'd0,4'd6,26'h3,4'b0000,64'h1000,64'h0,64'h0,4'd4,1'b0,64'h1004,1'b0,1'b0,1'b0},
      '{3'd2,1'b0,1'b0,6'd0,4'd4,26'h3,4'b1000,64'h1000,64'h0,64'h0,4'd4,1'b1,64'h100C,1'b0,1'b0,1'b0},
      // R5 / R11: most negative 26-bit jump (-128 MiB)
      '{3'd3,1'b0,1'b0,6'd0,4'd0,26'h200_0000,4'h0,64'h1000_0000,64'h0,64'h0,4'd5,1'b1,64'h0800_0000,1'b0,1'b0,1'b0},
      // R7: call with most positive offset
      '{3'd4,1'b0,1'b0,6'd0,4'd0,26'h1FF_FFFF,4'h0,64'h1000,64'h0,64'h0,4'd7,1'b1,64'h800_0FFC,1'b1,1'b0,1'b0},
      // R8 / R9: register jump, register call, return
      '{3'd5,1'b0,1'b0,6'd0,4'd0,26'h4,4'h0,64'h3000,64'h0,64'hDEAD_BEE0,4'd9,1'b1,64'hDEAD_BEE0,1'b0,1'b0,1'b1},
      '{3'd6,1'b0,1'b0,6'd0,4'd0,26'h4,4'h0,64'h2000,64'h0,64'h4000,4'd7,1'b1,64'h4000,1'b1,1'b0,1'b0},
      '{3'd7,1'b0,1'b0,6'd0,4'd0,26'h4,4'h0,64'h2000,64'h0,64'h5550,4'd9,1'b1,64'h5550,1'b0,1'b1,1'b0}
   };

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      in_valid = 1'b0; in_kind = 3'd0; in_invert = 1'b0; in_wide = 1'b0;
      in_bit = '0; in_cond = '0; in_imm = '0; in_reg_given = 1'b0; in_reg_idx = '0;
      in_pc = '0; in_opnd = '0; in_tgt = '0; in_flags = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual expired expected completion");
      finish_run();
   end

   initial begin
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: reset state
      chk("R10", "valid", 64'(out_valid), 64'd0);
      chk("R10", "taken", 64'(out_taken), 64'd0);
      chk("R10", "link_we", 64'(out_link_we), 64'd0);
      chk("R10", "hints", 64'({out_hint_ret, out_hint_jmp}), 64'd0);
      chk("R10", "next_pc", out_next_pc, 64'd0);
      rst_n = 1'b1;

      // table walk, back to back, one cycle latency (R1)
      for (int i = 0; i < NV; i++) begin
         string rq;
         rq = $sformatf("R%0d", VEC[i].req);
         in_valid = 1'b1; in_kind = VEC[i].kind; in_invert = VEC[i].inv;
         in_wide = VEC[i].wide; in_bit = VEC[i].bitn; in_cond = VEC[i].cond;
         in_imm = VEC[i].imm; in_flags = VEC[i].flags; in_pc = VEC[i].pc;
         in_opnd = VEC[i].opnd; in_tgt = VEC[i].tgt;
         @(posedge clk);
         @(negedge clk);
         chk("R1", $sformatf("valid v%0d", i), 64'(out_valid), 64'd1);
         chk(rq, $sformatf("taken v%0d", i), 64'(out_taken), 64'(VEC[i].e_taken));
         chk(rq, $sformatf("next_pc v%0d", i), out_next_pc, VEC[i].e_next);
         chk("R7", $sformatf("link_we v%0d", i), 64'(out_link_we), 64'(VEC[i].e_link));
         chk("R9", $sformatf("hint_ret v%0d", i), 64'(out_hint_ret), 64'(VEC[i].e_ret));
         chk("R9", $sformatf("hint_jmp v%0d", i), 64'(out_hint_jmp), 64'(VEC[i].e_jmp));
         if (VEC[i].kind >= 3'd3)
            chk("R11", $sformatf("uncond v%0d", i), 64'(out_taken), 64'd1);
         if (!VEC[i].e_taken)
            chk("R6", $sformatf("seq v%0d", i), out_next_pc, VEC[i].pc + 64'd4);
         if (VEC[i].e_link) begin
            chk("R7", $sformatf("link_idx v%0d", i), 64'(out_link_idx), 64'd30);
            chk("R7", $sformatf("link_data v%0d", i), out_link_data, VEC[i].pc + 64'd4);
         end
      end

      // R10 / R1: an idle call descriptor produces nothing
      in_valid = 1'b0; in_kind = 3'd4;
      @(posedge clk);
      @(negedge clk);
      chk("R1", "idle valid", 64'(out_valid), 64'd0);
      chk("R10", "idle link_we", 64'(out_link_we), 64'd0);
      chk("R10", "idle taken", 64'(out_taken), 64'd0);

      // R8: target register select (combinational)
      in_kind = 3'd7; in_reg_given = 1'b0; in_reg_idx = 5'd9;
      #1 chk("R8", "ret default sel", 64'(tgt_sel), 64'd30);
      in_reg_given = 1'b1;
      #1 chk("R8", "ret given sel", 64'(tgt_sel), 64'd9);
      in_kind = 3'd5; in_reg_given = 1'b0; in_reg_idx = 5'd12;
      #1 chk("R8", "jreg sel", 64'(tgt_sel), 64'd12);

      // R10: reset in the middle of traffic clears the result
      @(negedge clk);
      in_valid = 1'b1; in_kind = 3'd7; in_tgt = 64'h7770;
      @(posedge clk);
      @(negedge clk);
      chk("R9", "ret before reset", 64'(out_hint_ret), 64'd1);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R10", "reset valid", 64'(out_valid), 64'd0);
      chk("R10", "reset hint", 64'(out_hint_ret), 64'd0);
      chk("R10", "reset next_pc", out_next_pc, 64'd0);
      idle_inputs();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule